// File: doc/BRIEF.md
# Address Match Breakpoint Unit

This block watches a processor address bus and raises an active-high breakpoint signal when the bus carries one programmed address. Software programs the address as two bytes, a low byte and a high byte. It also writes a control byte. That byte turns the compare on or off and picks one of two output behaviours. The first is a pulse of fixed length. The second is a level that stays high until software releases it.

Every qualified match also sets a sticky status flag in the control byte. Software clears the flag by writing 1 to its bit. All three registers sit on a small byte-wide port with a write enable, a two-bit register select and combinational read-back. The bus address passes through one register stage before the compare. This keeps the compare off the bus timing path and makes the output one cycle later.

Top module: `addr_bkpt_unit`

## Requirements
- R1: The bus address is captured on each rising clock edge. When the captured value equals the programmed address {high byte, low byte} and the unit is enabled, the output goes high from the next rising edge onward. That is the second edge after the address is first presented. Any other address produces no output.
- R2: While the enable bit (control bit 0) is 0, a matching address does not raise the output and does not set the status bit.
- R3: In pulse mode (control bit 1 = 1), a match that lasts one cycle holds the output high for exactly PULSE_LEN cycles. PULSE_LEN defaults to 8.
- R4: In pulse mode, a new match while a pulse is running restarts the count from PULSE_LEN. The output then stays high for PULSE_LEN cycles after the last match.
- R5: In latched mode (control bit 1 = 0), a match drives the output high. It stays high until software writes 1 to the status bit (control bit 2).
- R6: The status bit (control bit 2) is set on every qualified match in either mode. Writing 0 to it leaves it unchanged. Writing 1 clears it. A match in the same cycle as a clearing write wins, and the bit stays set.
- R7: A control write with the enable bit at 0 ends a running pulse or a held level, and the output is low from that edge. The status bit is left unchanged unless the same write also carries a 1 in bit 2.
- R8: After reset the output is low and the low, high and control registers all read 0.
- R9: Register select 0 is the low address byte, 1 is the high address byte, 2 is control, and 3 reads 0 and ignores writes. A write takes effect on the edge where write enable is high, and read data reflects the selected register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W | Processor address bus being watched |
| regWe | input | 1 | Register write enable |
| regAddr | input | 2 | Register select |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Read-back of the selected register |
| brkOut | output | 1 | Breakpoint signal, active high |

## Verification
The bench uses the default parameters: a 16-bit bus, byte-wide registers and an 8-cycle pulse. With a 16-bit bus, every bus value can be walked past a programmed address in about 65,000 cycles. Each value's expected output comes from its distance to the match index, so a wrong bit in either byte of the compare, an off-by-one in the pulse length, or a wrong pipeline delay all show up in that one sweep. Directed sequences then cover retrigger, the latched level, disabling mid-event, the status write rules and reprogramming the address.

// File: rtl/bpw_pkg.sv
package bpw_pkg;
  localparam int CTRL_EN    = 0;
  localparam int CTRL_PULSE = 1;
  localparam int CTRL_STAT  = 2;

  typedef enum logic [1:0] {
    REG_LO   = 2'd0,
    REG_HI   = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLo;
    logic loadHi;
  } dpStrobe_t;
endpackage

// File: rtl/bpw_datapath.sv
module bpw_datapath
  import bpw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] addrLoByte,
  output logic [DATA_W-1:0] addrHiByte,
  output logic              match
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] addrLoQ;
  logic [HI_W-1:0]   addrHiQ;
  logic [ADDR_W-1:0] busQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLoQ <= '0;
      addrHiQ <= '0;
      busQ    <= '0;
    end else begin
      busQ <= busAddr;
      if (strb.loadLo) addrLoQ <= regWdata;
      if (strb.loadHi) addrHiQ <= regWdata[HI_W-1:0];
    end
  end

  assign match      = (busQ == {addrHiQ, addrLoQ});
  assign addrLoByte = addrLoQ;
  generate
    if (HI_W < DATA_W) begin : g_hiPad
      assign addrHiByte = {{(DATA_W-HI_W){1'b0}}, addrHiQ};
    end else begin : g_hiFull
      assign addrHiByte = addrHiQ;
    end
  endgenerate

  // R9
  lo_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadLo && rstN) |=> (addrLoByte == $past(regWdata)));
endmodule

// File: rtl/bpw_control.sv
module bpw_control
  import bpw_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PULSE_LEN = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              match,
  output dpStrobe_t         strb,
  output logic [DATA_W-1:0] ctrlByte,
  output logic              brkOut
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  logic             enQ, pulseModeQ, statusQ, holdQ;
  logic [CNT_W-1:0] cntQ;
  logic             ctlWr, hit, w1c, killWr;

  assign ctlWr  = regWe && (regAddr == REG_CTRL);
  assign hit    = enQ && match;
  assign w1c    = ctlWr && regWdata[CTRL_STAT];
  assign killWr = ctlWr && !regWdata[CTRL_EN];

  assign strb.loadLo = regWe && (regAddr == REG_LO);
  assign strb.loadHi = regWe && (regAddr == REG_HI);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ        <= 1'b0;
      pulseModeQ <= 1'b0;
      statusQ    <= 1'b0;
      holdQ      <= 1'b0;
      cntQ       <= '0;
    end else begin
      if (ctlWr) begin
        enQ        <= regWdata[CTRL_EN];
        pulseModeQ <= regWdata[CTRL_PULSE];
      end
      if (hit)      statusQ <= 1'b1;
      else if (w1c) statusQ <= 1'b0;

      if (killWr)                  holdQ <= 1'b0;
      else if (hit && !pulseModeQ) holdQ <= 1'b1;
      else if (w1c)                holdQ <= 1'b0;

      if (killWr)                 cntQ <= '0;
      else if (hit && pulseModeQ) cntQ <= CNT_W'(PULSE_LEN);
      else if (cntQ != '0)        cntQ <= cntQ - CNT_W'(1);
    end
  end

  assign brkOut   = holdQ || (cntQ != '0);
  assign ctrlByte = {{(DATA_W-3){1'b0}}, statusQ, pulseModeQ, enQ};

  // R6
  status_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> statusQ);
  // R6
  status_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ && !w1c) |=> statusQ);
  // R2
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enQ |-> !brkOut);
  // R3
  pulse_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CNT_W'(PULSE_LEN));
  // R4
  pulse_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hit && pulseModeQ && !killWr) |=> (cntQ == CNT_W'(PULSE_LEN)));
  // R5
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdQ && !w1c && !killWr) |=> brkOut);
endmodule

// File: rtl/addr_bkpt_unit.sv
module addr_bkpt_unit
  import bpw_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PULSE_LEN = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              brkOut
);
  dpStrobe_t         strb;
  logic              match;
  logic [DATA_W-1:0] loByte, hiByte, ctrlByte;

  bpw_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWdata(regWdata),
    .busAddr(busAddr), .addrLoByte(loByte), .addrHiByte(hiByte),
    .match(match)
  );

  bpw_control #(.DATA_W(DATA_W), .PULSE_LEN(PULSE_LEN)) u_ctl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .match(match), .strb(strb),
    .ctrlByte(ctrlByte), .brkOut(brkOut)
  );

  always_comb begin
    case (regAddr)
      REG_LO:   regRdata = loByte;
      REG_HI:   regRdata = hiByte;
      REG_CTRL: regRdata = ctrlByte;
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: tb/addr_bkpt_unit_bench.sv
module addr_bkpt_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] BP = 16'hA55A;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic       regWe = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       brkOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_bkpt_unit u_addr_bkpt_unit (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .brkOut(brkOut)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    tick();
    regWe = 1'b0;
  endtask

  task automatic rdChk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    regAddr = a;
    #1;
    chk(regRdata == exp, tag, regRdata, exp);
  endtask

  task automatic brkChk(input bit exp, input string tag);
    chk(brkOut == exp, tag, brkOut, exp);
  endtask

  initial begin
    repeat (3) tick();
    // R8 reset state
    brkChk(0, "R8 output low in reset");
    rdChk(2'd0, 8'h00, "R8 low byte reset");
    rdChk(2'd1, 8'h00, "R8 high byte reset");
    rdChk(2'd2, 8'h00, "R8 control reset");
    rstN = 1'b1;
    tick();

    // R9 register access
    wr(2'd0, BP[7:0]);
    wr(2'd1, BP[15:8]);
    wr(2'd3, 8'hFF);
    rdChk(2'd0, BP[7:0], "R9 low byte readback");
    rdChk(2'd1, BP[15:8], "R9 high byte readback");
    rdChk(2'd3, 8'h00, "R9 unused select reads zero");
    wr(2'd2, 8'h03);
    rdChk(2'd2, 8'h03, "R9 control readback");

    // R1 R3 full sweep of the bus in pulse mode
    for (int t = 0; t < 65546; t++) begin
      busAddr = (t <= 65535) ? 16'(t) : 16'h0000;
      tick();
      begin
        int d;
        bit exp;
        d = t - 1 - int'(BP);
        exp = (d >= 0) && (d < 8);
        chk(brkOut == exp, "R1/R3 sweep", brkOut, exp);
      end
    end
    // R6 status set, write 0 keeps, write 1 clears
    rdChk(2'd2, 8'h07, "R6 status set by match");
    wr(2'd2, 8'h03);
    rdChk(2'd2, 8'h07, "R6 writing zero keeps status");
    wr(2'd2, 8'h07);
    rdChk(2'd2, 8'h03, "R6 writing one clears status");

    // R4 retrigger
    for (int t = 0; t < 21; t++) begin
      busAddr = (t == 0 || t == 5) ? BP : 16'h0000;
      tick();
      brkChk((t >= 1) && (t <= 13), "R4 retrigger");
    end

    // R7 disable ends a pulse, status kept
    busAddr = BP; tick(); busAddr = 16'h0000;
    tick(); tick();
    brkChk(1, "R7 pulse running before disable");
    wr(2'd2, 8'h02);
    brkChk(0, "R7 pulse cut by disable");
    rdChk(2'd2, 8'h06, "R7 status kept on disable");
    wr(2'd2, 8'h06);
    rdChk(2'd2, 8'h02, "R6 clear while disabled");

    // R2 matches ignored while disabled
    busAddr = BP;
    for (int t = 0; t < 6; t++) begin
      tick();
      if (t == 2) busAddr = 16'h0000;
      brkChk(0, "R2 no output when disabled");
    end
    rdChk(2'd2, 8'h02, "R2 status untouched when disabled");

    // R5 latched level
    wr(2'd2, 8'h01);
    busAddr = BP; tick(); busAddr = 16'h0000;
    for (int t = 0; t < 20; t++) begin
      tick();
      brkChk(1, "R5 latched level held");
    end
    rdChk(2'd2, 8'h05, "R5 status in latched mode");
    wr(2'd2, 8'h01);
    brkChk(1, "R5 writing zero keeps level");
    wr(2'd2, 8'h05);
    brkChk(0, "R5 write one releases level");
    rdChk(2'd2, 8'h01, "R5 status cleared");

    // R6 match wins over clearing write
    busAddr = BP; tick(); tick();
    wr(2'd2, 8'h05);
    rdChk(2'd2, 8'h05, "R6 match beats clear");
    brkChk(1, "R6 level kept when match beats clear");
    busAddr = 16'h0000; tick(); tick();
    wr(2'd2, 8'h05);
    brkChk(0, "R6 later clear releases");

    // R7 disable drops latched level, status kept
    busAddr = BP; tick(); busAddr = 16'h0000; tick();
    brkChk(1, "R7 latched before disable");
    wr(2'd2, 8'h00);
    brkChk(0, "R7 latched dropped by disable");
    rdChk(2'd2, 8'h04, "R7 status kept latched");

    // R1 reprogrammed address
    wr(2'd0, 8'h34);
    wr(2'd1, 8'h12);
    wr(2'd2, 8'h07);
    busAddr = BP;
    for (int t = 0; t < 10; t++) begin
      tick();
      brkChk(0, "R1 old address ignored");
    end
    busAddr = 16'h1234; tick();
    busAddr = 16'h0000;
    brkChk(0, "R1 not yet high one edge after capture");
    tick();
    brkChk(1, "R1 new address matches");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule